// File: doc/BRIEF.md
# Serial Configuration Word Loader for a Dual Synthesizer

This block receives configuration words for two frequency synthesizer channels over a three-wire serial port: a data line, a serial clock and a load strobe. All three inputs are already synchronous to the system clock, and the block finds their edges there. While the load strobe is low, each rising serial clock edge moves one data bit into a 23-bit shift register. The word is sent most significant position first.

When the load strobe rises, the two positions that arrived last act as an address. They pick one of four holding registers: reference setup or main divider setup, for channel 0 or channel 1. The two kinds of word place their fields differently inside the frame, and the address says which placement applies. A word whose division ratio is one of the prohibited small values is refused. The target register keeps its contents and a one-cycle error pulse is raised. Every field is presented decoded and registered on per-channel output vectors, each with a valid flag.

Top module: `synth_cfg_loader`

## Requirements
- R1: Each cycle in which `ser_clk` is high after being low while `ser_le` is low shifts `ser_dat` into the frame. A frame is 23 bits. Numbering positions 1 to 23, position 23 is sent first and position 1 last.
- R2: Rising `ser_clk` edges that occur while `ser_le` is high leave the shift register unchanged.
- R3: A rising `ser_le` performs exactly one transfer, however long `ser_le` then stays high.
- R4: Position 1 is the channel select (0 = channel 0, 1 = channel 1). Position 2 selects the word kind (0 = reference setup, 1 = main divider setup). Each load writes at most one holding register.
- R5: Reference word layout: positions 3 and 4 go to `ref_test` bits 0 and 1, positions 5 to 18 form `ref_div` with its LSB at position 5, and position 19 goes to `ref_cp_hi`. Positions 20 to 23 are ignored.
- R6: Main divider word layout: position 3 goes to `main_lds`, position 4 to `main_presc` and position 5 to `main_fc`. Positions 6 to 12 form `main_a` (LSB first) and positions 13 to 23 form `main_n` (LSB first).
- R7: A reference word with a ratio below 3, or a main word with `main_n` below 3, leaves every holding register unchanged. It raises `bad_word` for exactly one cycle, in the cycle after the load edge. `main_a` has no lower limit, so 0 is accepted.
- R8: After reset all outputs are zero. A valid flag sets on the first legal load of its register and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, synchronous to clk |
| ser_dat | input | 1 | Serial data |
| ser_le | input | 1 | Load strobe; a rising edge transfers the frame |
| ref_div | output | 2x14 | Reference ratio per channel |
| ref_test | output | 2x2 | Test field per channel |
| ref_cp_hi | output | 2 | Pump current select per channel |
| ref_vld | output | 2 | Reference register loaded |
| main_n | output | 2x11 | Main counter ratio per channel |
| main_a | output | 2x7 | Swallow count per channel |
| main_lds | output | 2 | Lock/monitor output select per channel |
| main_presc | output | 2 | Prescaler modulus select per channel |
| main_fc | output | 2 | Phase detector polarity per channel |
| main_vld | output | 2 | Main register loaded |
| bad_word | output | 1 | One-cycle pulse on a refused word |

## Verification
The hardest case to reach is a serial clock edge arriving during a held load strobe, because a normal host never produces it. The bench loads a word, toggles `ser_clk` with ones on the data line while `ser_le` stays high, then pulses `ser_le` again without shifting anything. If the shift register had been corrupted, the reload would show up in a different register. Refused words are produced by biasing a quarter of the random ratios toward 0 to 4. One of them is sent under a strobe held for many cycles, so that the number of error pulses also shows how many transfers took place.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  parameter int NCH    = 2;   // channels addressed by position 1
  parameter int RW     = 14;  // reference ratio width
  parameter int NW     = 11;  // main counter width
  parameter int AW     = 7;   // swallow counter width
  parameter int MINDIV = 3;   // smallest legal ratio
  localparam int FW    = 5 + AW + NW;  // frame length
  localparam int R_LSB = 4;
  localparam int A_LSB = 5;
  localparam int N_LSB = A_LSB + AW;

  typedef struct packed {
    logic [1:0]    test;
    logic [RW-1:0] r;
    logic          cp_hi;
  } ref_word_t;

  typedef struct packed {
    logic          lds;
    logic          presc;
    logic          fc;
    logic [AW-1:0] a;
    logic [NW-1:0] n;
  } main_word_t;

  function automatic ref_word_t get_ref(input logic [FW-1:0] f);
    ref_word_t w;
    w.test  = f[3:2];
    w.r     = f[R_LSB +: RW];
    w.cp_hi = f[R_LSB + RW];
    return w;
  endfunction

  function automatic main_word_t get_main(input logic [FW-1:0] f);
    main_word_t w;
    w.lds   = f[2];
    w.presc = f[3];
    w.fc    = f[4];
    w.a     = f[A_LSB +: AW];
    w.n     = f[N_LSB +: NW];
    return w;
  endfunction

  function automatic logic ratio_ok(input logic [RW-1:0] v);
    return v >= RW'(MINDIV);
  endfunction
endpackage

// File: rtl/cfg_shift_in.sv
module cfg_shift_in
  import cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_le,
  output logic [FW-1:0] frame,
  output logic          load_evt
);
  logic sck_q, le_q;
  logic shift_evt;

  // Previous levels start high so a level present at reset is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b1;
      le_q  <= 1'b1;
    end else begin
      sck_q <= ser_clk;
      le_q  <= ser_le;
    end
  end

  assign shift_evt = ser_clk & ~sck_q & ~ser_le;
  assign load_evt  = ser_le & ~le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         frame <= '0;
    else if (shift_evt) frame <= {frame[FW-2:0], ser_dat};
  end

  AST_SHIFT_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> frame[0] == $past(ser_dat)); // R1
  AST_LE_FREEZES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |=> $stable(frame)); // R2
endmodule

// File: rtl/cfg_route.sv
module cfg_route
  import cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FW-1:0]  frame,
  input  logic           load_evt,
  output logic [NCH-1:0] wr_ref,
  output logic [NCH-1:0] wr_main,
  output logic           bad_word
);
  logic       is_main;
  logic       legal;
  logic [RW-1:0] ratio;

  assign is_main = frame[1];
  assign ratio   = is_main ? RW'(get_main(frame).n) : get_ref(frame).r;
  assign legal   = ratio_ok(ratio);

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign wr_ref[c]  = load_evt & legal & ~is_main & (frame[0] == c[0]);
    assign wr_main[c] = load_evt & legal &  is_main & (frame[0] == c[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_word <= 1'b0;
    else        bad_word <= load_evt & ~legal;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ref, wr_main})); // R4
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_word |=> !bad_word); // R7
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !legal) |-> (wr_ref == '0 && wr_main == '0)); // R7
endmodule

// File: rtl/cfg_hold_bank.sv
module cfg_hold_bank
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ref,
  input  logic       wr_main,
  input  ref_word_t  ref_in,
  input  main_word_t main_in,
  output ref_word_t  ref_q,
  output main_word_t main_q,
  output logic       ref_vld,
  output logic       main_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      ref_vld <= 1'b0;
    end else if (wr_ref) begin
      ref_q   <= ref_in;
      ref_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q   <= '0;
      main_vld <= 1'b0;
    end else if (wr_main) begin
      main_q   <= main_in;
      main_vld <= 1'b1;
    end
  end

  AST_REF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ref |=> $stable(ref_q)); // R7
  AST_MAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_main |=> $stable(main_q)); // R7
  AST_VLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_vld || main_vld) |=> ($past(ref_vld) <= ref_vld) && ($past(main_vld) <= main_vld)); // R8
  AST_REF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld |-> ref_q.r >= RW'(MINDIV)); // R7
  AST_MAIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    main_vld |-> main_q.n >= NW'(MINDIV)); // R7
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import cfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk,
  input  logic                   ser_dat,
  input  logic                   ser_le,
  output logic [NCH-1:0][RW-1:0] ref_div,
  output logic [NCH-1:0][1:0]    ref_test,
  output logic [NCH-1:0]         ref_cp_hi,
  output logic [NCH-1:0]         ref_vld,
  output logic [NCH-1:0][NW-1:0] main_n,
  output logic [NCH-1:0][AW-1:0] main_a,
  output logic [NCH-1:0]         main_lds,
  output logic [NCH-1:0]         main_presc,
  output logic [NCH-1:0]         main_fc,
  output logic [NCH-1:0]         main_vld,
  output logic                   bad_word
);
  logic [FW-1:0]  frame;
  logic           load_evt;
  logic [NCH-1:0] wr_ref, wr_main;
  ref_word_t      ref_in;
  main_word_t     main_in;

  cfg_shift_in u_shift (
    .clk, .rst_n, .ser_clk, .ser_dat, .ser_le,
    .frame, .load_evt
  );

  cfg_route u_route (
    .clk, .rst_n, .frame, .load_evt,
    .wr_ref, .wr_main, .bad_word
  );

  assign ref_in  = get_ref(frame);
  assign main_in = get_main(frame);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ref_word_t  rq;
    main_word_t mq;

    cfg_hold_bank u_bank (
      .clk, .rst_n,
      .wr_ref (wr_ref[c]),
      .wr_main(wr_main[c]),
      .ref_in, .main_in,
      .ref_q  (rq),
      .main_q (mq),
      .ref_vld(ref_vld[c]),
      .main_vld(main_vld[c])
    );

    assign ref_div[c]    = rq.r;
    assign ref_test[c]   = rq.test;
    assign ref_cp_hi[c]  = rq.cp_hi;
    assign main_n[c]     = mq.n;
    assign main_a[c]     = mq.a;
    assign main_lds[c]   = mq.lds;
    assign main_presc[c] = mq.presc;
    assign main_fc[c]    = mq.fc;
  end
endmodule

// File: tb/synth_cfg_loader_bench.sv
module synth_cfg_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [1:0][13:0] ref_div;
  logic [1:0][1:0]  ref_test;
  logic [1:0]       ref_cp_hi, ref_vld;
  logic [1:0][10:0] main_n;
  logic [1:0][6:0]  main_a;
  logic [1:0]       main_lds, main_presc, main_fc, main_vld;
  logic             bad_word;

  always #2.5 clk = ~clk;

  synth_cfg_loader u_synth_cfg_loader (.*);

  int checks = 0, errors = 0, err_seen = 0, e_err = 0;
  logic [13:0] e_r[2];  logic [1:0] e_t[2]; logic e_cs[2], e_rv[2];
  logic [10:0] e_n[2];  logic [6:0] e_a[2];
  logic e_lds[2], e_sw[2], e_fc[2], e_mv[2];

  always @(negedge clk) if (rst_n && bad_word === 1'b1) err_seen++;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input longint act, input longint exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Frames built bit by bit; index k-1 holds position k
  function automatic logic [22:0] mk_ref(input int ch, input logic [13:0] r,
                                         input logic [1:0] t, input logic cs);
    logic [22:0] w = 23'($urandom);
    w[0] = ch[0]; w[1] = 1'b0; w[2] = t[0]; w[3] = t[1];
    for (int i = 0; i < 14; i++) w[4+i] = r[i];
    w[18] = cs;
    return w;
  endfunction

  function automatic logic [22:0] mk_main(input int ch, input logic [10:0] n,
      input logic [6:0] a, input logic lds, input logic sw, input logic fc);
    logic [22:0] w;
    w[0] = ch[0]; w[1] = 1'b1; w[2] = lds; w[3] = sw; w[4] = fc;
    for (int i = 0; i < 7; i++)  w[5+i] = a[i];
    for (int i = 0; i < 11; i++) w[12+i] = n[i];
    return w;
  endfunction

  task automatic shift_frame(input logic [22:0] w);
    for (int i = 22; i >= 0; i--) begin
      ser_dat = w[i]; tick(1);
      ser_clk = 1'b1; tick(2);
      ser_clk = 1'b0; tick(1);
    end
  endtask

  task automatic strobe(input int hold);
    ser_le = 1'b1; tick(hold);
    ser_le = 1'b0; tick(2);
  endtask

  task automatic send_ref(input int ch, input logic [13:0] r, input logic [1:0] t,
                          input logic cs, input int hold);
    shift_frame(mk_ref(ch, r, t, cs));
    strobe(hold);
    if (r >= 3) begin e_r[ch] = r; e_t[ch] = t; e_cs[ch] = cs; e_rv[ch] = 1; end
    else e_err++;
  endtask

  task automatic send_main(input int ch, input logic [10:0] n, input logic [6:0] a,
                           input logic lds, input logic sw, input logic fc);
    shift_frame(mk_main(ch, n, a, lds, sw, fc));
    strobe(3);
    if (n >= 3) begin
      e_n[ch] = n; e_a[ch] = a; e_lds[ch] = lds; e_sw[ch] = sw; e_fc[ch] = fc; e_mv[ch] = 1;
    end else e_err++;
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < 2; c++) begin
      check({ref_div[c], ref_test[c], ref_cp_hi[c], ref_vld[c]},
            {e_r[c], e_t[c], e_cs[c], e_rv[c]}, {tag, " R5 ref fields"});
      check({main_n[c], main_a[c], main_lds[c], main_presc[c], main_fc[c], main_vld[c]},
            {e_n[c], e_a[c], e_lds[c], e_sw[c], e_fc[c], e_mv[c]}, {tag, " R6 main fields"});
    end
    check(err_seen, e_err, {tag, " R7 error pulses"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0C1));
    for (int c = 0; c < 2; c++) begin
      e_r[c] = 0; e_t[c] = 0; e_cs[c] = 0; e_rv[c] = 0;
      e_n[c] = 0; e_a[c] = 0; e_lds[c] = 0; e_sw[c] = 0; e_fc[c] = 0; e_mv[c] = 0;
    end
    tick(4); rst_n = 1'b1; tick(3);
    check_all("R8 reset");

    // R4 address decode: each destination in turn, others untouched
    send_ref(0, 14'd1000, 2'b01, 1'b1, 3);  check_all("R4 ch0 ref");
    send_ref(1, 14'd16383, 2'b10, 1'b0, 3); check_all("R4 ch1 ref");
    send_main(0, 11'd2047, 7'd0, 1, 0, 1);  check_all("R4 ch0 main a=0");
    send_main(1, 11'd3, 7'd127, 0, 1, 0);   check_all("R4 ch1 main n=3");
    check({ref_vld, main_vld}, 4'hF, "R8 all valid");

    // R7 boundary: ratio 2 refused, 3 accepted
    send_ref(0, 14'd2, 2'b11, 1'b0, 3);     check_all("R7 ref=2 refused");
    send_main(1, 11'd0, 7'd5, 1, 1, 1);     check_all("R7 n=0 refused");
    send_ref(0, 14'd3, 2'b00, 1'b0, 3);     check_all("R7 ref=3 accepted");

    // R3: long strobe on a refused word gives one pulse only
    send_ref(1, 14'd1, 2'b01, 1'b1, 20);    check_all("R3 long strobe");

    // R2: serial clock pulses under a held strobe are ignored
    shift_frame(mk_ref(1, 14'd777, 2'b11, 1'b1));
    ser_le = 1'b1; tick(2);
    e_r[1] = 14'd777; e_t[1] = 2'b11; e_cs[1] = 1'b1; e_rv[1] = 1;
    for (int k = 0; k < 5; k++) begin
      ser_dat = 1'b1; ser_clk = 1'b1; tick(2); ser_clk = 1'b0; tick(2);
    end
    ser_le = 1'b0; tick(2);
    strobe(3);
    check_all("R2 clock during strobe");

    // R1: bit order exercised by random words
    for (int k = 0; k < 50; k++) begin
      int ch = $urandom_range(0, 1);
      bit sml = ($urandom % 4) == 0;
      if ($urandom % 2) begin
        logic [13:0] r = sml ? 14'($urandom_range(0, 4)) : 14'($urandom_range(3, 16383));
        send_ref(ch, r, 2'($urandom), 1'($urandom), 3);
      end else begin
        logic [10:0] n = sml ? 11'($urandom_range(0, 4)) : 11'($urandom_range(3, 2047));
        send_main(ch, n, 7'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      check_all("R1 random word");
    end
    summary();
  end
endmodule